// File: doc/BRIEF.md
# Compact-ISA Register ALU Unit

This block carries out the sixteen two-register data-processing operations of a 16-bit compressed RISC instruction set. The surrounding core decodes the instruction and reads the register file. It then presents a 4-bit opcode, the first operand (which is also the destination value), the second operand and the current carry and overflow flags, and pulses `start`. The unit returns the 32-bit result, a writeback enable, updated N/Z/C/V flags and the number of cycles the operation costs.

Most operations finish in their base cycle. Register-specified shifts and rotates cost one extra internal cycle. Multiply costs one to four extra cycles, chosen by the highest nonzero byte of the first operand. A configuration input can select a fixed three-cycle multiply instead. While extra cycles are counted the unit is busy and ignores new requests. `done` pulses once when the operation completes. The outputs then hold until the next accepted request.

Top module: `reg_alu_core`

## Requirements
- R1: During and straight after reset, `busy`, `done` and `wr_en` are low and `result`, `flags_out` and `cycles` are zero.
- R2: Opcodes 0 (AND), 1 (EOR), 12 (ORR), 14 (BIC, a & ~b) and 15 (MVN, ~b) write the result with `wr_en`=1. `flags_out` packs N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. These opcodes set N from result bit 31 and Z when the result is zero, and copy C from `carry_in` and V from `ovf_in`.
- R3: Opcodes 8 (TST, a & b), 10 (CMP, a - b) and 11 (CMN, a + b) drive `wr_en`=0 and update N and Z. CMP sets C to "no borrow" (a >= b unsigned) and V on signed overflow of the subtraction. CMN sets C to the carry out of the addition and V on its signed overflow. TST keeps C and V.
- R4: Opcodes 2 (LSL), 3 (LSR), 4 (ASR) and 7 (ROR) shift operand a by op_b[7:0], ignoring op_b[31:8]. For amounts 1 to 31, C is the last bit shifted out. Amount 0 leaves the value and C unchanged. V is always kept.
- R5: At the shift boundaries: LSL by 32 gives 0 with C=a[0], and LSR by 32 gives 0 with C=a[31]. LSL or LSR by more than 32 gives 0 with C=0. ASR by 32 or more fills with a[31] and sets C=a[31]. ROR by a nonzero multiple of 32 returns a with C=a[31]. For other amounts, ROR rotates by the amount modulo 32 and C is the new bit 31.
- R6: Opcode 5 (ADC) computes a+b and then adds C. Its C is the OR of both step carries and its V is the OR of both step overflows. Opcode 6 (SBC) computes a-b and then subtracts NOT C. Its C is the AND of both steps' no-borrow and its V is the OR of both step overflows.
- R7: Opcode 9 (NEG) writes 0 - b, sets C only when b is zero, and sets V only when b is 0x80000000.
- R8: Opcode 13 (MUL) with `mul_fixed`=0 writes the low 32 bits of a*b and clears C. It takes 4, 3, 2 or 1 extra cycles when the highest nonzero byte of a is byte 3, 2, 1 or lower.
- R9: With `mul_fixed`=1, MUL takes exactly 3 extra cycles and keeps C and V.
- R10: `cycles` equals 1 plus the extra cycles, where the extra cycles are 1 for shifts and rotate, 0 for the other non-multiply opcodes, and as in R8/R9 for MUL. `done` is high for one cycle, `cycles` rising edges after the edge that samples `start` (counting that edge), and `busy` stays high while the unit waits for it.
- R11: A `start` while `busy` is ignored. Once done, `result`, `wr_en`, `flags_out` and `cycles` hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; accepted when not busy |
| opcode | input | 4 | Operation select, 0..15 |
| op_a | input | 32 | First operand / destination value |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Current C flag |
| ovf_in | input | 1 | Current V flag |
| mul_fixed | input | 1 | 1: fixed multiply latency, C kept |
| busy | output | 1 | Counting extra internal cycles |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination writeback enable |
| flags_out | output | 4 | Updated flags {N,Z,C,V} |
| cycles | output | 4 | Total cycle cost of the operation |

## Verification
The logic and compare opcodes are driven with inputs where C and V start set. This separates operations that must keep those flags from those that must overwrite them. Shifts are run at amounts 0, mid-range, 32, just above 32 and far above 32, and with upper amount bits set. This tells the edge-bit carry rule apart from the cleared-carry rule and shows that only the low byte counts. Add and subtract with carry are tried with both carry values and with an operand pair whose first step overflows but whose full sum does not. That pair tells the stepwise flag rule apart from a single wide add. Multiply operands with their top nonzero byte in each position, in both latency modes, separate the four variable latencies from the fixed one. A request made while busy confirms that it neither produces a second completion nor changes the held result.

// File: rtl/reg_alu_pkg.sv
package reg_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_EOR = 4'd1,
        OP_LSL = 4'd2,
        OP_LSR = 4'd3,
        OP_ASR = 4'd4,
        OP_ADC = 4'd5,
        OP_SBC = 4'd6,
        OP_ROR = 4'd7,
        OP_TST = 4'd8,
        OP_NEG = 4'd9,
        OP_CMP = 4'd10,
        OP_CMN = 4'd11,
        OP_ORR = 4'd12,
        OP_MUL = 4'd13,
        OP_BIC = 4'd14,
        OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    // bit positions inside the packed flag vector
    localparam int FL_N = 3;
    localparam int FL_Z = 2;
    localparam int FL_C = 1;
    localparam int FL_V = 0;

endpackage

// File: rtl/reg_alu_shift.sv
module reg_alu_shift
    import reg_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     a,
    input  logic [AMT_W-1:0] amt,
    input  shift_kind_e      kind,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout
);
    localparam int SH_W = $clog2(W);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

    logic signed [W:0] sx;
    logic [SH_W-1:0]   rot;

    assign sx  = {a, 1'b0};
    assign rot = amt[SH_W-1:0];

    always_comb begin
        res  = a;
        cout = cin;
        if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    if (amt <= W_AMT) begin
                        {cout, res} = {1'b0, a} << amt;
                    end else begin
                        res  = '0;
                        cout = 1'b0;
                    end
                end
                SH_LSR: begin
                    if (amt <= W_AMT) begin
                        {res, cout} = {a, 1'b0} >> amt;
                    end else begin
                        res  = '0;
                        cout = 1'b0;
                    end
                end
                SH_ASR: begin
                    if (amt < W_AMT) begin
                        {res, cout} = sx >>> amt;
                    end else begin
                        res  = {W{a[W-1]}};
                        cout = a[W-1];
                    end
                end
                SH_ROR: begin
                    res  = W'({a, a} >> rot);
                    cout = res[W-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/reg_alu_addsub.sv
module reg_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    input  logic         use_cin,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         vout
);
    localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

    logic [W:0]   s1;
    logic [W:0]   s2;
    logic [W-1:0] t;
    logic [W-1:0] y2;
    logic         v1;
    logic         v2;

    // second step adds the carry, or subtracts its inverse
    assign y2 = {{(W-1){1'b0}}, use_cin & (sub ? ~cin : cin)};

    always_comb begin
        if (sub) begin
            s1 = {1'b0, x} + {1'b0, ~y} + ONE;
        end else begin
            s1 = {1'b0, x} + {1'b0, y};
        end
        t = s1[W-1:0];
        if (sub) begin
            s2 = {1'b0, t} + {1'b0, ~y2} + ONE;
        end else begin
            s2 = {1'b0, t} + {1'b0, y2};
        end
        res = s2[W-1:0];
        if (sub) begin
            v1   = (x[W-1] != y[W-1])  && (t[W-1] != x[W-1]);
            v2   = (t[W-1] != y2[W-1]) && (res[W-1] != t[W-1]);
            cout = s1[W] & s2[W];
        end else begin
            v1   = (x[W-1] == y[W-1])  && (t[W-1] != x[W-1]);
            v2   = (t[W-1] == y2[W-1]) && (res[W-1] != t[W-1]);
            cout = s1[W] | s2[W];
        end
        vout = v1 | v2;
    end

endmodule

// File: rtl/reg_alu_mulcost.sv
module reg_alu_mulcost #(
    parameter int W           = 32,
    parameter int CNT_W       = 3,
    parameter int FIXED_EXTRA = 3
) (
    input  logic [W-9:0]     a_hi,
    input  logic             fixed,
    output logic [CNT_W-1:0] extra
);
    localparam int BYTES = W / 8;

    logic [BYTES-1:1] nz;

    for (genvar g = 1; g < BYTES; g++) begin : g_byte
        assign nz[g] = |a_hi[8*(g-1) +: 8];
    end

    always_comb begin
        extra = CNT_W'(1);
        for (int i = 1; i < BYTES; i++) begin
            if (nz[i]) extra = CNT_W'(i + 1);
        end
        if (fixed) extra = CNT_W'(FIXED_EXTRA);
    end

endmodule

// File: rtl/reg_alu_core.sv
module reg_alu_core
    import reg_alu_pkg::*;
#(
    parameter int W               = 32,
    parameter int AMT_W           = 8,
    parameter int CNT_W           = 3,
    parameter int MUL_FIXED_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        opcode,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic              carry_in,
    input  logic              ovf_in,
    input  logic              mul_fixed,
    output logic              busy,
    output logic              done,
    output logic [W-1:0]      result,
    output logic              wr_en,
    output logic [3:0]        flags_out,
    output logic [CNT_W:0]    cycles
);
    localparam int CYC_W = CNT_W + 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [W-1:0]     res;
        logic             wr;
        logic [3:0]       fl;
        logic [CYC_W-1:0] cyc;
    } state_t;

    state_t s_d, s_q;

    alu_op_e     op;
    shift_kind_e sh_kind;
    logic [W-1:0] sh_res, as_res, as_x, prod;
    logic         sh_c, as_c, as_v, as_sub, as_use_cin;
    logic [CNT_W-1:0] mul_extra;

    assign op   = alu_op_e'(opcode);
    assign prod = op_a * op_b;

    always_comb begin
        unique case (op)
            OP_LSR:  sh_kind = SH_LSR;
            OP_ASR:  sh_kind = SH_ASR;
            OP_ROR:  sh_kind = SH_ROR;
            default: sh_kind = SH_LSL;
        endcase
        as_x       = (op == OP_NEG) ? '0 : op_a;
        as_sub     = (op == OP_SBC) || (op == OP_CMP) || (op == OP_NEG);
        as_use_cin = (op == OP_ADC) || (op == OP_SBC);
    end

    reg_alu_shift #(.W(W), .AMT_W(AMT_W)) u_shift (
        .a    (op_a),
        .amt  (op_b[AMT_W-1:0]),
        .kind (sh_kind),
        .cin  (carry_in),
        .res  (sh_res),
        .cout (sh_c)
    );

    reg_alu_addsub #(.W(W)) u_addsub (
        .x       (as_x),
        .y       (op_b),
        .sub     (as_sub),
        .use_cin (as_use_cin),
        .cin     (carry_in),
        .res     (as_res),
        .cout    (as_c),
        .vout    (as_v)
    );

    reg_alu_mulcost #(.W(W), .CNT_W(CNT_W), .FIXED_EXTRA(MUL_FIXED_EXTRA)) u_mulcost (
        .a_hi  (op_a[W-1:8]),
        .fixed (mul_fixed),
        .extra (mul_extra)
    );

    always_comb begin
        logic [W-1:0]     r;
        logic             c_new, v_new, wr;
        logic [CNT_W-1:0] extra;

        s_d      = s_q;
        s_d.done = 1'b0;
        r        = '0;
        c_new    = carry_in;
        v_new    = ovf_in;
        wr       = 1'b1;
        extra    = '0;

        unique case (op)
            OP_AND: r = op_a & op_b;
            OP_EOR: r = op_a ^ op_b;
            OP_ORR: r = op_a | op_b;
            OP_BIC: r = op_a & ~op_b;
            OP_MVN: r = ~op_b;
            OP_TST: begin r = op_a & op_b; wr = 1'b0; end
            OP_LSL, OP_LSR, OP_ASR, OP_ROR: begin
                r     = sh_res;
                c_new = sh_c;
                extra = CNT_W'(1);
            end
            OP_ADC, OP_SBC, OP_NEG: begin
                r     = as_res;
                c_new = as_c;
                v_new = as_v;
            end
            OP_CMP, OP_CMN: begin
                r     = as_res;
                c_new = as_c;
                v_new = as_v;
                wr    = 1'b0;
            end
            OP_MUL: begin
                r     = prod;
                extra = mul_extra;
                if (!mul_fixed) c_new = 1'b0;
            end
        endcase

        if (s_q.busy) begin
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end else if (start) begin
            s_d.res = r;
            s_d.wr  = wr;
            s_d.fl  = {r[W-1], (r == '0), c_new, v_new};
            s_d.cyc = CYC_W'(extra) + CYC_W'(1);
            s_d.cnt = extra;
            if (extra == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign result    = s_q.res;
    assign wr_en     = s_q.wr;
    assign flags_out = s_q.fl;
    assign cycles    = s_q.cyc;

endmodule

// File: rtl/reg_alu_chk.sv
module reg_alu_chk
    import reg_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [3:0]   opcode,
    input logic         carry_in,
    input logic         ovf_in,
    input logic         mul_fixed,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic         wr_en,
    input logic [3:0]   flags_out
);
    logic take;
    assign take = start && !busy;

    // R10
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R11
    held_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(result) && $stable(flags_out) && $stable(wr_en)));

    // R3
    compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (opcode == OP_TST || opcode == OP_CMP || opcode == OP_CMN))
        |=> (done && !wr_en));

    // R4
    shift_one_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (opcode == OP_LSL || opcode == OP_LSR || opcode == OP_ASR || opcode == OP_ROR))
        |=> (busy && !done) ##1 (done && !busy));

    // R2
    logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (opcode == OP_AND || opcode == OP_EOR || opcode == OP_ORR ||
                  opcode == OP_BIC || opcode == OP_MVN))
        |=> (flags_out[FL_C] == $past(carry_in) && flags_out[FL_V] == $past(ovf_in)));

    // R9
    fixed_mul_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == OP_MUL && mul_fixed)
        |=> (busy && flags_out[FL_C] == $past(carry_in)));

endmodule

bind reg_alu_core reg_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opcode    (opcode),
    .carry_in  (carry_in),
    .ovf_in    (ovf_in),
    .mul_fixed (mul_fixed),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .wr_en     (wr_en),
    .flags_out (flags_out)
);

// File: tb/sim_reg_alu_core.sv
`timescale 1ns/1ps
module sim_reg_alu_core;
    import reg_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        carry_in = 1'b0, ovf_in = 1'b0, mul_fixed = 1'b0;
    logic        busy, done, wr_en;
    logic [31:0] result;
    logic [3:0]  flags_out;
    logic [3:0]  cycles;

    reg_alu_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .ovf_in(ovf_in),
        .mul_fixed(mul_fixed), .busy(busy), .done(done), .result(result),
        .wr_en(wr_en), .flags_out(flags_out), .cycles(cycles)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [31:0] res;
        logic        wr;
        logic [3:0]  fl;
        int          cyc;
        int          issue;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   n_chk = 0, n_fail = 0, cyc_cnt = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit ova(input logic [31:0] x, y, r);
        return (x[31] == y[31]) && (r[31] != x[31]);
    endfunction

    function automatic bit ovs(input logic [31:0] x, y, r);
        return (x[31] != y[31]) && (r[31] != x[31]);
    endfunction

    function automatic exp_t model(input logic [3:0] op, input logic [31:0] a, b,
                                   input logic ci, vi, input bit fx);
        exp_t e;
        logic [31:0] r, t, bin;
        logic [32:0] s1, s2;
        logic c, v;
        int amt, k, extra;
        c = ci; v = vi; r = '0; extra = 0; e.wr = 1'b1; amt = int'(b[7:0]);
        case (op)
            4'd0:  r = a & b;
            4'd1:  r = a ^ b;
            4'd2: begin
                extra = 1;
                if (amt == 0) r = a;
                else if (amt < 32) begin r = a << amt; c = a[32-amt]; end
                else if (amt == 32) begin r = '0; c = a[0]; end
                else begin r = '0; c = 1'b0; end
            end
            4'd3: begin
                extra = 1;
                if (amt == 0) r = a;
                else if (amt < 32) begin r = a >> amt; c = a[amt-1]; end
                else if (amt == 32) begin r = '0; c = a[31]; end
                else begin r = '0; c = 1'b0; end
            end
            4'd4: begin
                extra = 1;
                if (amt == 0) r = a;
                else if (amt < 32) begin r = $unsigned($signed(a) >>> amt); c = a[amt-1]; end
                else begin r = {32{a[31]}}; c = a[31]; end
            end
            4'd5: begin
                s1 = {1'b0, a} + {1'b0, b}; t = s1[31:0];
                s2 = {1'b0, t} + {32'b0, ci}; r = s2[31:0];
                c = s1[32] | s2[32];
                v = ova(a, b, t) | ova(t, {31'b0, ci}, r);
            end
            4'd6: begin
                t = a - b; bin = {31'b0, ~ci}; r = t - bin;
                c = (a >= b) && (t >= bin);
                v = ovs(a, b, t) | ovs(t, bin, r);
            end
            4'd7: begin
                extra = 1;
                if (amt == 0) r = a;
                else begin
                    k = amt % 32;
                    r = (k == 0) ? a : ((a >> k) | (a << (32 - k)));
                    c = r[31];
                end
            end
            4'd8:  begin r = a & b; e.wr = 1'b0; end
            4'd9:  begin r = 32'd0 - b; c = (b == 0); v = (b == 32'h8000_0000); end
            4'd10: begin r = a - b; c = (a >= b); v = ovs(a, b, r); e.wr = 1'b0; end
            4'd11: begin s1 = {1'b0, a} + {1'b0, b}; r = s1[31:0]; c = s1[32]; v = ova(a, b, r); e.wr = 1'b0; end
            4'd12: r = a | b;
            4'd13: begin
                r = a * b;
                if (fx) extra = 3;
                else begin
                    extra = (a[31:24] != 0) ? 4 : (a[23:16] != 0) ? 3 : (a[15:8] != 0) ? 2 : 1;
                    c = 1'b0;
                end
            end
            4'd14: r = a & ~b;
            default: r = ~b;
        endcase
        e.res = r;
        e.fl  = {r[31], (r == 0), c, v};
        e.cyc = 1 + extra;
        return e;
    endfunction

    // monitor: pops expected items when the design signals completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 32'd1, 32'd0);
            end else begin
                mon_e = sbq.pop_front();
                chk(result == mon_e.res, {mon_e.tag, " result"}, result, mon_e.res);
                chk(flags_out == mon_e.fl, {mon_e.tag, " flags"}, 32'(flags_out), 32'(mon_e.fl));
                chk(wr_en == mon_e.wr, {mon_e.tag, " wr_en"}, 32'(wr_en), 32'(mon_e.wr));
                chk(32'(cycles) == mon_e.cyc, {mon_e.tag, " R10 cycles"}, 32'(cycles), mon_e.cyc);
                chk(cyc_cnt - mon_e.issue == mon_e.cyc, {mon_e.tag, " R10 latency"},
                    cyc_cnt - mon_e.issue, mon_e.cyc);
            end
        end
    end

    task automatic drive(input logic [3:0] op, input logic [31:0] a, b,
                         input logic ci, vi, input bit fx);
        opcode = op; op_a = a; op_b = b; carry_in = ci; ovf_in = vi; mul_fixed = fx;
        start = 1'b1;
    endtask

    task automatic run(input logic [3:0] op, input logic [31:0] a, b,
                       input logic ci, vi, input bit fx, input string tag);
        exp_t e;
        e = model(op, a, b, ci, vi, fx);
        e.tag = tag;
        e.issue = cyc_cnt;
        sbq.push_back(e);
        drive(op, a, b, ci, vi, fx);
        @(negedge clk);
        start = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual no completion expected done");
            summary();
        end
    end

    initial begin
        exp_t ei;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en, "R1 reset controls", {busy, done, wr_en}, 0);
        chk(result == 0 && flags_out == 0 && cycles == 0, "R1 reset data", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && result == 0, "R1 after release", result, 0);

        // R2 logic ops with C and V preset
        run(OP_AND, 32'hF0F0_1234, 32'h0FF0_FF00, 1, 1, 0, "R2 AND");
        run(OP_EOR, 32'h8000_00FF, 32'h0000_00FF, 0, 1, 0, "R2 EOR");
        run(OP_ORR, 32'h1200_0000, 32'h0000_0034, 1, 0, 0, "R2 ORR");
        run(OP_BIC, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1, 1, 0, "R2 BIC");
        run(OP_MVN, 32'h0, 32'hFFFF_FFFF, 1, 1, 0, "R2 MVN zero");

        // R3 compare-only ops
        run(OP_TST, 32'hF0, 32'h0F, 0, 1, 0, "R3 TST zero");
        run(OP_CMP, 32'd7, 32'd7, 0, 0, 0, "R3 CMP equal");
        run(OP_CMP, 32'd1, 32'd2, 1, 0, 0, "R3 CMP borrow");
        run(OP_CMP, 32'h8000_0000, 32'd1, 0, 0, 0, "R3 CMP overflow");
        run(OP_CMN, 32'hFFFF_FFFF, 32'd1, 0, 1, 0, "R3 CMN carry");

        // R4 shifts, mid-range and zero amounts, upper amount bits ignored
        run(OP_LSL, 32'h8123_4567, 32'h0000_0104, 0, 1, 0, "R4 LSL 4");
        run(OP_LSR, 32'h0000_0003, 32'd1, 0, 0, 0, "R4 LSR 1");
        run(OP_ASR, 32'h8000_0010, 32'd4, 0, 0, 0, "R4 ASR 4");
        run(OP_ROR, 32'h0000_00A5, 32'd8, 0, 0, 0, "R4 ROR 8");
        run(OP_LSL, 32'h1234_5678, 32'hFFFF_FF00, 1, 1, 0, "R4 amount 0");
        run(OP_ASR, 32'h8000_0000, 32'h0000_0100, 1, 0, 0, "R4 ASR amount 0");

        // R5 boundaries
        run(OP_LSL, 32'h0000_0001, 32'd32, 0, 0, 0, "R5 LSL 32");
        run(OP_LSL, 32'hFFFF_FFFF, 32'd33, 1, 0, 0, "R5 LSL 33");
        run(OP_LSR, 32'h8000_0000, 32'd32, 0, 0, 0, "R5 LSR 32");
        run(OP_LSR, 32'hFFFF_FFFF, 32'd40, 1, 0, 0, "R5 LSR 40");
        run(OP_ASR, 32'h8000_0001, 32'd32, 0, 0, 0, "R5 ASR 32 neg");
        run(OP_ASR, 32'h7FFF_FFFF, 32'd200, 1, 0, 0, "R5 ASR 200 pos");
        run(OP_ROR, 32'h8000_0001, 32'd32, 0, 0, 0, "R5 ROR 32");
        run(OP_ROR, 32'h0000_0010, 32'd36, 0, 0, 0, "R5 ROR 36");

        // R6 carry arithmetic
        run(OP_ADC, 32'd10, 32'd20, 1, 0, 0, "R6 ADC cin");
        run(OP_ADC, 32'h8000_0000, 32'hFFFF_FFFF, 1, 0, 0, "R6 ADC stepwise");
        run(OP_SBC, 32'd5, 32'd3, 0, 0, 0, "R6 SBC borrow in");
        run(OP_SBC, 32'd3, 32'd5, 1, 0, 0, "R6 SBC negative");

        // R7 negate
        run(OP_NEG, 32'h0, 32'd5, 0, 0, 0, "R7 NEG 5");
        run(OP_NEG, 32'h0, 32'd0, 0, 1, 0, "R7 NEG 0");
        run(OP_NEG, 32'h0, 32'h8000_0000, 0, 0, 0, "R7 NEG min");

        // R8 variable multiply latency
        run(OP_MUL, 32'd3, 32'd7, 1, 1, 0, "R8 MUL byte0");
        run(OP_MUL, 32'h0000_0100, 32'd9, 1, 0, 0, "R8 MUL byte1");
        run(OP_MUL, 32'h0001_0000, 32'hFFFF_FFFF, 1, 0, 0, "R8 MUL byte2");
        run(OP_MUL, 32'h0100_0000, 32'd2, 1, 0, 0, "R8 MUL byte3");

        // R9 fixed multiply latency
        run(OP_MUL, 32'h0100_0000, 32'd3, 1, 1, 1, "R9 MUL fixed big");
        run(OP_MUL, 32'd4, 32'd5, 1, 0, 1, "R9 MUL fixed small");

        // R11 request during busy is ignored, outputs held afterwards
        ei = model(OP_MUL, 32'h0100_0000, 32'd3, 0, 0, 0);
        ei.tag = "R11 first op";
        ei.issue = cyc_cnt;
        sbq.push_back(ei);
        drive(OP_MUL, 32'h0100_0000, 32'd3, 0, 0, 0);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R11 busy during mul", 32'(busy), 32'd1);
        drive(OP_AND, 32'hFFFF_FFFF, 32'h1234_5678, 1, 1, 0);
        @(negedge clk);
        start = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(result == ei.res, "R11 result held", result, ei.res);
        chk(flags_out == ei.fl, "R11 flags held", 32'(flags_out), 32'(ei.fl));

        repeat (2) @(negedge clk);
        summary();
    end

endmodule